// File: doc/BRIEF.md
# Video Core Interrupt Aggregator

This block gathers two event sources inside a video output core into one interrupt line. The first source is a mode-selection update: the mode-match logic pulses an input when a newly selected video mode has been written into its match register. The second source is frame lock: a level input that goes high once the outgoing start-of-frame lines up with the incoming start-of-frame. Each source owns a sticky status bit that is set on the rising edge of its input.

Software programs a control word to pick which sources may drive the interrupt line. It reads the status word to see which events have happened, and clears them by writing ones. A status bit records its event whether or not the matching enable bit is set. The enable bits only gate the shared output line.

The register port has separate write and read addresses. Writes take effect at the clock edge. Read data is combinational from the current read address. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `vid_irq_combiner`

## Requirements
- R1: While reset is asserted and after it is released, the status bits and enable bits are zero, `irq_o` is low, and every register address reads zero.
- R2: `irq_o` is high exactly when at least one status bit is set whose enable bit is also set. It follows register changes in the same cycle.
- R3: A rising edge on `mode_update_i` sets status bit 1 (mode-change) at the next clock edge. The bit is read at address 1. Holding the input high sets the bit only once.
- R4: A low-to-high transition of `sof_locked_i` sets status bit 2 (frame lock) at the next clock edge. While the input stays high, a cleared bit is not set again.
- R5: The control register at address 0 holds the enable bits. Bit 1 enables the mode-change source and bit 2 enables the frame-lock source. Both are written by a write to address 0 and read back at bits [2:1]. All other bits read as zero.
- R6: A status bit is set by its event even when its enable bit is zero. It stays set until it is cleared.
- R7: Writing a 1 to bit 1 or bit 2 at address 1 clears that status bit. Writing a 0 leaves it unchanged.
- R8: If an event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R9: Writes to address 1 never set a status bit. Writes to addresses 2 and 3 change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| mode_update_i | input | 1 | Goes high when a new mode is written into the mode-match register |
| sof_locked_i | input | 1 | High while the output start-of-frame is aligned to the input start-of-frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Write address (0 = control, 1 = status) |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 2 | Read address |
| reg_rdata_o | output | 32 | Read data for `reg_raddr_i` |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Each state register shows up at the ports within one cycle of being wrong. A lost or extra status bit appears in the status word on the cycle after the event edge. A bad enable bit appears in the control read-back right after the write. Because the interrupt line is combinational from these registers, any wrong masking or OR term shows on `irq_o` in the same cycle. A missing edge detector gives a second set of a bit that was just cleared, visible one cycle after the clearing write while the lock input is held high.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;

  // Number of event sources feeding the shared line.
  localparam int unsigned NUM_SRC = 2;

  // Index of each source inside the status and enable vectors.
  typedef enum int unsigned {
    SRC_MODE = 0,
    SRC_LOCK = 1
  } irq_src_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = level_i[i] & ~prev_q[i];

    // A level held high yields one event only.
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= level_i;
    end
  end

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] upd_en;

  // Next state: an event beats a clear.
  always_comb begin
    upd_en   = set_i | clr_i;
    status_d = set_i | (status_q & ~clr_i);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
      end else if (upd_en[i]) begin
        status_q[i] <= status_d[i];
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> status_q[i]); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !status_q[i]); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr_i[i]) |=> status_q[i]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[i] && !set_i[i]) |=> !status_q[i]); // R9
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_csr.sv
module irq_csr #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NSRC      = 2,
  parameter int unsigned FIELD_LSB = 1,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   enable_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned FIELD_MSB = FIELD_LSB + NSRC - 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic            ctrl_wr;
  logic            stat_wr;
  logic [NSRC-1:0] enable_q;
  logic [NSRC-1:0] enable_d;

  always_comb begin
    ctrl_wr  = wr_i && (waddr_i == CTRL_A);
    stat_wr  = wr_i && (waddr_i == STAT_A);
    enable_d = wdata_i[FIELD_MSB:FIELD_LSB];
    clr_o    = stat_wr ? wdata_i[FIELD_MSB:FIELD_LSB] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (ctrl_wr) begin
      enable_q <= enable_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i == CTRL_A) begin
      rdata_o[FIELD_MSB:FIELD_LSB] = enable_q;
    end else if (raddr_i == STAT_A) begin
      rdata_o[FIELD_MSB:FIELD_LSB] = status_i;
    end
  end

  assign enable_o = enable_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(enable_q)); // R5
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (enable_q == $past(wdata_i[FIELD_MSB:FIELD_LSB]))); // R5

endmodule

// File: rtl/vid_irq_combiner.sv
module vid_irq_combiner
  import vid_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FIELD_LSB   = 1,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned STAT_ADDR   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_update_i,
  input  logic              sof_locked_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic                rst_sync_n;
  logic [NUM_SRC-1:0]  src_level;
  logic [NUM_SRC-1:0]  src_rise;
  logic [NUM_SRC-1:0]  src_clr;
  logic [NUM_SRC-1:0]  src_status;
  logic [NUM_SRC-1:0]  src_enable;
  logic                ctrl_write;

  always_comb begin
    src_level           = '0;
    src_level[SRC_MODE] = mode_update_i;
    src_level[SRC_LOCK] = sof_locked_i;
    ctrl_write          = reg_wr_i && (reg_waddr_i == ADDR_W'(CTRL_ADDR));
  end

  irq_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irq_edge_capture #(
    .WIDTH (NUM_SRC)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (src_level),
    .rise_o  (src_rise)
  );

  irq_sticky_bank #(
    .WIDTH (NUM_SRC)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (src_rise),
    .clr_i    (src_clr),
    .status_o (src_status)
  );

  irq_csr #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NSRC      (NUM_SRC),
    .FIELD_LSB (FIELD_LSB),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_csr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_i     (reg_wr_i),
    .waddr_i  (reg_waddr_i),
    .wdata_i  (reg_wdata_i),
    .raddr_i  (reg_raddr_i),
    .status_i (src_status),
    .enable_o (src_enable),
    .clr_o    (src_clr),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = |(src_status & src_enable);

  // The line can only rise after an event edge or a control write.
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> $past((|src_rise) || ctrl_write)); // R2
  // The line can only fall after a clearing write or a control write.
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_o) |-> $past(reg_wr_i)); // R7

endmodule

// File: tb/vid_irq_combiner_test.sv
module vid_irq_combiner_test;

  logic        clk;
  logic        rst_n;
  logic        mode_update_i;
  logic        sof_locked_i;
  logic        reg_wr_i;
  logic [1:0]  reg_waddr_i;
  logic [31:0] reg_wdata_i;
  logic [1:0]  reg_raddr_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  vid_irq_combiner uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_update_i (mode_update_i),
    .sof_locked_i  (sof_locked_i),
    .reg_wr_i      (reg_wr_i),
    .reg_waddr_i   (reg_waddr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_raddr_i   (reg_raddr_i),
    .reg_rdata_o   (reg_rdata_o),
    .irq_o         (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: [10] mode, [9] lock, [8] wr, [7:6] waddr, [5:3] wdata[2:0],
  // [2] expected irq, [1:0] expected status {lock, mode}.
  localparam int NVEC = 14;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b1_0_0_00_000_0_01, // R3 R6 mode edge sets bit 1 with enable off
    11'b0_0_1_00_010_1_01, // R5 R2 enable mode source
    11'b0_1_0_00_000_1_11, // R4 lock edge sets bit 2
    11'b0_1_1_01_100_1_01, // R7 clear lock bit
    11'b0_1_0_00_000_1_01, // R4 lock held, no re-set
    11'b0_1_1_01_000_1_01, // R7 zero write leaves bits
    11'b0_1_1_01_010_0_00, // R7 clear mode bit
    11'b1_1_1_01_010_1_01, // R8 event beats clear
    11'b1_1_1_00_100_0_01, // R2 R3 mask mode, held mode no re-set
    11'b0_0_0_00_000_0_01, // R4 lock drops
    11'b0_1_0_00_000_1_11, // R4 second lock edge
    11'b0_1_1_00_000_0_11, // R2 all masked, status kept
    11'b0_1_1_01_110_0_00, // R7 clear both
    11'b0_1_1_11_110_0_00  // R9 unmapped write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode_update_i = 1'b0;
    reg_wr_i      = 1'b0;
    reg_waddr_i   = 2'd0;
    reg_wdata_i   = '0;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i    = 1'b1;
    reg_waddr_i = a;
    reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i    = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    sof_locked_i = 1'b0;
    reg_raddr_i  = 2'd1;
    idle();
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    check("R1 status in reset", reg_rdata_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 status after reset", reg_rdata_o, 32'h0);
    reg_raddr_i = 2'd0;
    #1;
    check("R1 control after reset", reg_rdata_o, 32'h0);
    reg_raddr_i = 2'd1;

    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      v = VEC[i];
      @(negedge clk);
      mode_update_i = v[10];
      sof_locked_i  = v[9];
      reg_wr_i      = v[8];
      reg_waddr_i   = v[7:6];
      reg_wdata_i   = {29'b0, v[5:3]};
      @(negedge clk);
      idle();
      mode_update_i = v[10];
      #1;
      check($sformatf("R2 irq vector %0d", i), {31'b0, irq_o}, {31'b0, v[2]});
      check($sformatf("R7 status vector %0d", i), reg_rdata_o, {29'b0, v[1:0], 1'b0});
    end
    idle();

    // R5 read-back keeps only bits [2:1]
    write_reg(2'd0, 32'hFFFF_FFFF);
    reg_raddr_i = 2'd0;
    #1;
    check("R5 control read-back", reg_rdata_o, 32'h6);
    // R9 writes to unmapped address change nothing
    write_reg(2'd2, 32'h0);
    #1;
    check("R9 control after unmapped write", reg_rdata_o, 32'h6);
    reg_raddr_i = 2'd3;
    #1;
    check("R9 unmapped read", reg_rdata_o, 32'h0);
    reg_raddr_i = 2'd1;

    // R3 single-cycle pulse with both enables set
    @(negedge clk);
    mode_update_i = 1'b1;
    @(negedge clk);
    mode_update_i = 1'b0;
    #1;
    check("R3 mode pulse sets bit 1", reg_rdata_o, 32'h2);
    check("R2 irq from mode", {31'b0, irq_o}, 32'h1);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 irq cleared by reset", {31'b0, irq_o}, 32'h0);
    check("R1 status cleared by reset", reg_rdata_o, 32'h0);
    reg_raddr_i = 2'd0;
    #1;
    check("R1 control cleared by reset", reg_rdata_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule